// File: doc/BRIEF.md
# Bit-Serial Adder with Operand Shift Registers

This block adds two unsigned operands one bit per clock. Each operand sits in its own shift register, and each register has a two-bit mode input. On every addition step, the least significant bits of both registers are combined with a stored carry. The resulting sum bit enters operand register A at its most significant end as A shifts right. Operand register B rotates, so its value is intact once the addition ends. The carry between bit positions is held in a JK flip-flop. Its J and K inputs are derived from the two operand bits, so the flip-flop sets, resets or holds exactly as a full-adder carry would.

A step counter allows exactly WIDTH steps per addition and then raises a completion flag. After that, the run input has no further effect. A typical use is to clear the block, load both operands in parallel, and hold run high. When the flag rises, register A holds the sum modulo 2^WIDTH and the carry flip-flop holds the carry out. Loading a new value into register A re-arms the counter, which starts the next addition.

Top module: `serial_adder_top`

## Requirements
- R1: While rst_n is low, a_q, b_q, carry_q and done are all 0.
- R2: When clr is high at a clock edge, a_q, b_q, carry_q, done and the step counter are all zero after that edge. Clear takes priority over run and over the mode inputs.
- R3: The mode code 2'b10 is a parallel load. It applies on any edge with clr low that is not a step. The register takes load_a or load_b. A load of register A also zeroes carry_q, done and the step counter.
- R4: Mode codes 2'b00 and 2'b11 always hold the register. Code 2'b01 also holds when the cycle is not a step, because shifting happens only during a step.
- R5: A step is an edge with clr low, run high and done low. Both registers then shift right whatever their mode codes are. Let x = a_q[0], y = b_q[0] and c = carry_q. The new a_q[WIDTH-1] is x^y^c. The new carry_q is set when x&y, cleared when neither x nor y is set, and otherwise kept.
- R6: After exactly WIDTH steps, done becomes 1, a_q equals (A+B) mod 2^WIDTH and carry_q equals bit WIDTH of A+B. Before the WIDTH-th step, done is 0.
- R7: During a step, b_q rotates right, with b_q[0] entering at bit WIDTH-1. After WIDTH steps, b_q equals its loaded value.
- R8: While done is 1, holding run high leaves a_q, b_q and carry_q unchanged.
- R9: After k steps with 0 < k < WIDTH, the top k bits of a_q hold the low k bits of A+B, and the low WIDTH-k bits hold A shifted right by k. carry_q then equals bit k of (A mod 2^k)+(B mod 2^k).
- R10: With WIDTH = 4, A = 4'b1101 and B = 4'b1011, the result is a_q = 4'b1000 and carry_q = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of registers, carry and counter |
| run | input | 1 | Serial step enable |
| mode_a | input | 2 | Mode code for register A (00 hold, 01 shift, 10 load, 11 hold) |
| mode_b | input | 2 | Mode code for register B (same encoding) |
| load_a | input | WIDTH | Parallel value for register A |
| load_b | input | WIDTH | Parallel value for register B |
| a_q | output | WIDTH | Register A: operand, partial sum, then sum |
| b_q | output | WIDTH | Register B: operand, rotating |
| carry_q | output | 1 | Carry flip-flop |
| done | output | 1 | WIDTH steps completed |

## Verification
A wrong carry decode or sum bit appears at the top of a_q on the very next edge, so checking every intermediate step exposes it within one cycle. A step counter that is off by one moves the rise of done by one cycle and leaves a partial or over-rotated value in a_q and b_q, which the final check catches after WIDTH steps. Sweeping all 256 operand pairs covers every carry pattern, so a JK drive that fails only for one input combination still shows up. A gating fault after done appears within one extra run cycle as a change in a_q, b_q or carry_q.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD     = 2'b00,
      MODE_SHIFT    = 2'b01,
      MODE_LOAD     = 2'b10,
      MODE_HOLD_ALT = 2'b11
   } sa_mode_e;

   function automatic logic carry_majority(input logic x, input logic y, input logic c);
      return (x & y) | (x & c) | (y & c);
   endfunction

endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg
   import serial_adder_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q
);

   localparam int TOP = WIDTH - 1;

   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] nxt;
   sa_mode_e         mode_e;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sa_shift_reg: WIDTH must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == TOP) begin : g_top
            assign shifted[i] = ser_in;
         end else begin : g_mid
            assign shifted[i] = q[i+1];
         end
      end
   endgenerate

   always_comb begin
      mode_e = sa_mode_e'(mode);
      nxt    = q;
      if (clr) begin
         nxt = '0;
      end else if (step) begin
         nxt = shifted;
      end else begin
         case (mode_e)
            MODE_LOAD: nxt = par_in;
            default:   nxt = q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/sa_jk_cell.sv
module sa_jk_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic j,
   input  logic k,
   output logic q
);

   logic nxt;

   always_comb begin
      nxt = q;
      if (clr) begin
         nxt = 1'b0;
      end else if (en) begin
         case ({j, k})
            2'b10:   nxt = 1'b1;
            2'b01:   nxt = 1'b0;
            2'b11:   nxt = ~q;
            default: nxt = q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end

endmodule

// File: rtl/sa_bit_adder.sv
module sa_bit_adder (
   input  logic x,
   input  logic y,
   input  logic c,
   output logic sum,
   output logic j,
   output logic k
);

   assign sum = x ^ y ^ c;
   assign j   = x & y;
   assign k   = ~x & ~y;

endmodule

// File: rtl/sa_step_counter.sv
module sa_step_counter #(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic restart,
   input  logic step,
   output logic done
);

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (clr || restart) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (step) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
   import serial_adder_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic [WIDTH-1:0] load_a,
   input  logic [WIDTH-1:0] load_b,
   output logic [WIDTH-1:0] a_q,
   output logic [WIDTH-1:0] b_q,
   output logic             carry_q,
   output logic             done
);

   logic step;
   logic load_a_evt;
   logic sum_bit;
   logic jk_j;
   logic jk_k;
   logic carry_clr;

   assign step       = run & ~done & ~clr;
   assign load_a_evt = ~clr & ~step & (sa_mode_e'(mode_a) == MODE_LOAD);
   assign carry_clr  = clr | load_a_evt;

   sa_bit_adder u_add (
      .x   (a_q[0]),
      .y   (b_q[0]),
      .c   (carry_q),
      .sum (sum_bit),
      .j   (jk_j),
      .k   (jk_k)
   );

   sa_shift_reg #(.WIDTH(WIDTH)) u_reg_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .step   (step),
      .mode   (mode_a),
      .par_in (load_a),
      .ser_in (sum_bit),
      .q      (a_q)
   );

   sa_shift_reg #(.WIDTH(WIDTH)) u_reg_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .step   (step),
      .mode   (mode_b),
      .par_in (load_b),
      .ser_in (b_q[0]),
      .q      (b_q)
   );

   sa_jk_cell u_carry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (carry_clr),
      .en    (step),
      .j     (jk_j),
      .k     (jk_k),
      .q     (carry_q)
   );

   sa_step_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .restart (load_a_evt),
      .step    (step),
      .done    (done)
   );

endmodule

// File: rtl/serial_adder_checker.sv
module serial_adder_checker #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             run,
   input logic [1:0]       mode_a,
   input logic [1:0]       mode_b,
   input logic [WIDTH-1:0] load_a,
   input logic [WIDTH-1:0] a_q,
   input logic [WIDTH-1:0] b_q,
   input logic             carry_q,
   input logic             done
);

   logic is_step;
   assign is_step = run & ~done & ~clr;

   always_comb begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (a_q == '0 && b_q == '0 && !carry_q && !done);
      end
   end

   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (a_q == '0 && b_q == '0 && !carry_q && !done));

   a_r3_load_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !is_step && mode_a == 2'b10) |=> (a_q == $past(load_a) && !carry_q && !done));

   a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !is_step && mode_a != 2'b10) |=> $stable(a_q));

   a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
      is_step |=> carry_q == serial_adder_pkg::carry_majority($past(a_q[0]), $past(b_q[0]), $past(carry_q)));

   a_r5_sum_in: assert property (@(posedge clk) disable iff (!rst_n)
      is_step |=> a_q[WIDTH-1] == ($past(a_q[0]) ^ $past(b_q[0]) ^ $past(carry_q)));

   a_r7_b_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      is_step |=> b_q == {$past(b_q[0]), $past(b_q[WIDTH-1:1])});

   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr && mode_a != 2'b10 && mode_b != 2'b10) |=>
         ($stable(a_q) && $stable(b_q) && $stable(carry_q) && done));

endmodule

bind serial_adder_top serial_adder_checker #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .run     (run),
   .mode_a  (mode_a),
   .mode_b  (mode_b),
   .load_a  (load_a),
   .a_q     (a_q),
   .b_q     (b_q),
   .carry_q (carry_q),
   .done    (done)
);

// File: tb/serial_adder_top_tb.sv
module serial_adder_top_tb;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0;
   logic         run = 1'b0;
   logic [1:0]   mode_a = 2'b00;
   logic [1:0]   mode_b = 2'b00;
   logic [W-1:0] load_a = '0;
   logic [W-1:0] load_b = '0;
   logic [W-1:0] a_q;
   logic [W-1:0] b_q;
   logic         carry_q;
   logic         done;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   serial_adder_top #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
      .mode_a(mode_a), .mode_b(mode_b), .load_a(load_a), .load_b(load_b),
      .a_q(a_q), .b_q(b_q), .carry_q(carry_q), .done(done)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_both(input int a, input int b);
      run = 1'b0; mode_a = 2'b10; mode_b = 2'b10;
      load_a = W'(a); load_b = W'(b);
      tick();
      mode_a = 2'b00; mode_b = 2'b00;
   endtask

   // runs a full addition, checking every intermediate step (R9) and the result (R6, R7)
   task automatic add_and_check(input int a, input int b, input bit detail);
      load_both(a, b);
      run = 1'b1;
      for (int k = 1; k <= W; k++) begin
         tick();
         if (detail || k == W) begin
            int m = (1 << k) - 1;
            int s = a + b;
            int ea = (((s & m) << (W - k)) | (a >> k)) & ((1 << W) - 1);
            int ec = (((a & m) + (b & m)) >> k) & 1;
            if (k < W) begin
               chk("R9 partial a_q", a_q, ea);
               chk("R9 partial carry", carry_q, ec);
               chk("R6 done low early", done, 0);
            end else begin
               chk("R6 sum", a_q, s & ((1 << W) - 1));
               chk("R6 carry out", carry_q, (s >> W) & 1);
               chk("R6 done", done, 1);
               chk("R7 b restored", b_q, b);
            end
         end
      end
      run = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      chk("R1 a_q", a_q, 0); chk("R1 b_q", b_q, 0);
      chk("R1 carry", carry_q, 0); chk("R1 done", done, 0);
      rst_n = 1'b1;
      tick();

      // R10 worked example 1101 + 1011
      add_and_check(4'b1101, 4'b1011, 1'b1);
      chk("R10 sum", a_q, 4'b1000);
      chk("R10 carry", carry_q, 1);

      // R8 run after done has no effect
      run = 1'b1;
      repeat (3) tick();
      chk("R8 a held", a_q, 4'b1000); chk("R8 b held", b_q, 4'b1011);
      chk("R8 carry held", carry_q, 1); chk("R8 done", done, 1);
      run = 1'b0;

      // R3 load of A clears carry and done
      mode_a = 2'b10; load_a = 4'b0110;
      tick();
      mode_a = 2'b00;
      chk("R3 load a", a_q, 4'b0110); chk("R3 carry cleared", carry_q, 0);
      chk("R3 done cleared", done, 0); chk("R3 b untouched", b_q, 4'b1011);
      mode_b = 2'b10; load_b = 4'b0011;
      tick();
      mode_b = 2'b00;
      chk("R3 load b", b_q, 4'b0011); chk("R3 a kept", a_q, 4'b0110);

      // R4 hold codes with run low
      for (int md = 0; md < 4; md++) begin
         if (md == 2) continue;
         mode_a = 2'(md); mode_b = 2'(md); load_a = 4'b1111; load_b = 4'b1111;
         tick(); tick();
         chk("R4 a held", a_q, 4'b0110); chk("R4 b held", b_q, 4'b0011);
      end
      mode_a = 2'b00; mode_b = 2'b00;

      // R5 step ignores mode codes: load code during a step does not load
      load_both(4'b0111, 4'b0101);
      run = 1'b1; mode_a = 2'b10; mode_b = 2'b10; load_a = '0; load_b = '0;
      tick();
      chk("R5 a shifted", a_q, 4'b0011); chk("R5 carry set", carry_q, 1);
      chk("R5 b rotated", b_q, 4'b1010);
      run = 1'b0; mode_a = 2'b00; mode_b = 2'b00;

      // R2 clear mid-run, then counter restarts from zero
      load_both(4'b1010, 4'b0110);
      run = 1'b1;
      tick(); tick();
      clr = 1'b1;
      tick();
      clr = 1'b0;
      chk("R2 a", a_q, 0); chk("R2 b", b_q, 0);
      chk("R2 carry", carry_q, 0); chk("R2 done", done, 0);
      tick(); tick(); tick();
      chk("R2 counter restarted", done, 0);
      tick();
      chk("R2 done after full count", done, 1);
      run = 1'b0;

      // exhaustive sweep of all operand pairs
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            add_and_check(a, b, (a % 5) == 0);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule